// File: doc/BRIEF.md
# Saturating SIMD Multiply-Accumulate Unit

This combinational unit serves the three-operand multiply-add and multiply-subtract operations of a packed-integer datapath. It splits its operands into lanes. In each lane it takes either the lower or the upper half of two factor operands and multiplies those halves as signed values. It then adds the product to the matching lane of an accumulator operand, or subtracts the product from it. If a lane result falls outside the signed range of the lane, it is pinned to the nearest limit and never wraps.

A 3-bit function code chooses all three options. Bit 2 picks the lane width: 0 gives narrow lanes, 1 gives wide lanes of twice that width. Bit 1 picks subtraction and bit 0 picks the upper factor halves. With the default parameters the operands are 128 bits wide. The unit then works either as four 32-bit lanes with 16-bit factors or as two 64-bit lanes with 32-bit factors. The result is meant to be registered by the surrounding pipeline stage.

Top module: `simd_sat_mac`

## Requirements
- R1: `func_i[2]`=0 splits the operands into DATA_W/NARROW_W lanes of NARROW_W bits. `func_i[2]`=1 splits them into DATA_W/(2*NARROW_W) lanes of 2*NARROW_W bits. Lane k occupies bits [k*W+W-1 : k*W], where W is the lane width.
- R2: `func_i[0]`=0 takes factor bits [W/2-1:0] of each lane. `func_i[0]`=1 takes bits [W-1:W/2]. The unselected halves have no effect on the result.
- R3: With `func_i[1]`=0 and narrow lanes, each result lane is the signed addend lane plus the signed product of the selected halves of `fac_a_i` and `fac_b_i`.
- R4: With `func_i[1]`=1, each result lane is the addend lane minus that product.
- R5: With wide lanes, the same add or subtract is done with a signed W/2 x W/2 product and a W-bit addend.
- R6: A lane result above 2^(W-1)-1 becomes 2^(W-1)-1, and a result below -2^(W-1) becomes -2^(W-1).
- R7: The product of the most negative half by itself (for example -32768 x -32768 = 2^30) is passed on without clamping. Only the following accumulation can saturate.
- R8: A lane result depends only on that lane's operand bits. Saturation in one lane leaves the other lanes unchanged.
- R9: The parameter SIGN_CMP_OVF picks how overflow is detected. 0 uses a guard-bit accumulator and 1 compares operand and result signs. Both give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_i | input | 3 | Function code: [2] wide lanes, [1] subtract, [0] upper halves |
| addend_i | input | DATA_W | Accumulator operand, signed per lane |
| fac_a_i | input | DATA_W | First factor operand |
| fac_b_i | input | DATA_W | Second factor operand |
| res_o | output | DATA_W | Saturated lane results |

## Verification
The bench builds two instances with DATA_W=8 and NARROW_W=4, one for each overflow variant. Narrow lanes are then 4 bits with 2-bit factors and the single wide lane is 8 bits with 4-bit factors. At that size every accumulator and first-factor value can be swept under all eight function codes, so every saturation boundary and every half selection is reached. A third instance with the default 128-bit, 32-bit-lane configuration takes directed vectors: the most-negative-square products, saturation next to unsaturated lanes, and pseudo-random operands checked against a wide-integer reference.

// File: rtl/simd_sat_mac_pkg.sv
package simd_sat_mac_pkg;

   // Function code layout; bit order is decoded by the lanes.
   typedef struct packed {
      logic wide;   // [2] double-width lanes
      logic sub;    // [1] accumulator minus product
      logic hi;     // [0] upper factor halves
   } mac_fn_t;

   localparam int FN_W = 3;

endpackage

// File: rtl/sat_mac_lane.sv
module sat_mac_lane
   import simd_sat_mac_pkg::*;
#(
   parameter int LW           = 32,
   parameter bit SIGN_CMP_OVF = 1'b0
) (
   input  logic          hi_i,
   input  logic          sub_i,
   input  logic [LW-1:0] acc_i,
   input  logic [LW-1:0] fa_i,
   input  logic [LW-1:0] fb_i,
   output logic [LW-1:0] res_o
);

   localparam int HW = LW / 2;
   localparam logic [LW-1:0] MAX_V = {1'b0, {(LW-1){1'b1}}};
   localparam logic [LW-1:0] MIN_V = {1'b1, {(LW-1){1'b0}}};

   logic signed [HW-1:0] a_half, b_half;
   logic signed [LW-1:0] prod;
   logic                 ovf;
   logic                 ovf_neg;
   logic        [LW-1:0] raw;

   assign a_half = hi_i ? fa_i[LW-1:HW] : fa_i[HW-1:0];
   assign b_half = hi_i ? fb_i[LW-1:HW] : fb_i[HW-1:0];
   // A signed HW x HW product always fits in LW bits.
   assign prod   = a_half * b_half;

   generate
      if (SIGN_CMP_OVF) begin : g_sign_cmp
         logic signed [LW-1:0] sum;
         assign sum = sub_i ? ($signed(acc_i) - prod) : ($signed(acc_i) + prod);
         always_comb begin
            if (sub_i)
               ovf = (acc_i[LW-1] != prod[LW-1]) && (sum[LW-1] != acc_i[LW-1]);
            else
               ovf = (acc_i[LW-1] == prod[LW-1]) && (sum[LW-1] != acc_i[LW-1]);
         end
         assign ovf_neg = acc_i[LW-1];
         assign raw     = sum;
      end else begin : g_guard
         logic signed [LW:0] sum;
         assign sum = sub_i ? ($signed(acc_i) - prod) : ($signed(acc_i) + prod);
         assign ovf     = sum[LW] ^ sum[LW-1];
         assign ovf_neg = sum[LW];
         assign raw     = sum[LW-1:0];
      end
   endgenerate

   assign res_o = ovf ? (ovf_neg ? MIN_V : MAX_V) : raw;

endmodule

// File: rtl/simd_sat_mac.sv
module simd_sat_mac
   import simd_sat_mac_pkg::*;
#(
   parameter int DATA_W       = 128,
   parameter int NARROW_W     = 32,
   parameter bit SIGN_CMP_OVF = 1'b0
) (
   input  logic [FN_W-1:0]   func_i,
   input  logic [DATA_W-1:0] addend_i,
   input  logic [DATA_W-1:0] fac_a_i,
   input  logic [DATA_W-1:0] fac_b_i,
   output logic [DATA_W-1:0] res_o
);

   localparam int WIDE_W   = 2 * NARROW_W;
   localparam int N_NARROW = DATA_W / NARROW_W;
   localparam int N_WIDE   = DATA_W / WIDE_W;

   generate
      if (NARROW_W < 4 || (NARROW_W % 2) != 0) begin : g_bad_narrow
         $error("simd_sat_mac: NARROW_W must be even and at least 4");
      end
      if ((DATA_W % WIDE_W) != 0) begin : g_bad_data
         $error("simd_sat_mac: DATA_W must be a multiple of 2*NARROW_W");
      end
   endgenerate

   mac_fn_t              fn;
   logic    [DATA_W-1:0] narrow_res;
   logic    [DATA_W-1:0] wide_res;

   assign fn = mac_fn_t'(func_i);

   generate
      for (genvar n = 0; n < N_NARROW; n++) begin : g_narrow
         sat_mac_lane #(.LW(NARROW_W), .SIGN_CMP_OVF(SIGN_CMP_OVF)) u_lane (
            .hi_i  (fn.hi),
            .sub_i (fn.sub),
            .acc_i (addend_i[n*NARROW_W +: NARROW_W]),
            .fa_i  (fac_a_i [n*NARROW_W +: NARROW_W]),
            .fb_i  (fac_b_i [n*NARROW_W +: NARROW_W]),
            .res_o (narrow_res[n*NARROW_W +: NARROW_W])
         );
      end
      for (genvar w = 0; w < N_WIDE; w++) begin : g_wide
         sat_mac_lane #(.LW(WIDE_W), .SIGN_CMP_OVF(SIGN_CMP_OVF)) u_lane (
            .hi_i  (fn.hi),
            .sub_i (fn.sub),
            .acc_i (addend_i[w*WIDE_W +: WIDE_W]),
            .fa_i  (fac_a_i [w*WIDE_W +: WIDE_W]),
            .fb_i  (fac_b_i [w*WIDE_W +: WIDE_W]),
            .res_o (wide_res[w*WIDE_W +: WIDE_W])
         );
      end
   endgenerate

   assign res_o = fn.wide ? wide_res : narrow_res;

endmodule

// File: rtl/simd_sat_mac_chk.sv
module simd_sat_mac_chk #(
   parameter int DATA_W   = 128,
   parameter int NARROW_W = 32
) (
   input logic [2:0]        func_i,
   input logic [DATA_W-1:0] addend_i,
   input logic [DATA_W-1:0] fac_a_i,
   input logic [DATA_W-1:0] fac_b_i,
   input logic [DATA_W-1:0] res_o
);

   localparam int NW   = NARROW_W;
   localparam int NH   = NW / 2;
   localparam int WW   = 2 * NARROW_W;
   localparam int WH   = NARROW_W;
   localparam int N_NL = DATA_W / NW;
   localparam int N_WL = DATA_W / WW;
   localparam logic [NW-1:0] N_MAX = {1'b0, {(NW-1){1'b1}}};
   localparam logic [NW-1:0] N_MIN = {1'b1, {(NW-1){1'b0}}};

   logic known;
   assign known = !$isunknown({func_i, addend_i, fac_a_i, fac_b_i, res_o});

   generate
      for (genvar g = 0; g < N_NL; g++) begin : g_nl
         logic [NH-1:0] fa, fb;
         logic [NW-1:0] ac, rs;
         logic          nz_pos;
         assign fa = func_i[0] ? fac_a_i[g*NW+NH +: NH] : fac_a_i[g*NW +: NH];
         assign fb = func_i[0] ? fac_b_i[g*NW+NH +: NH] : fac_b_i[g*NW +: NH];
         assign ac = addend_i[g*NW +: NW];
         assign rs = res_o[g*NW +: NW];
         assign nz_pos = (fa != '0) && (fb != '0) && (fa[NH-1] == fb[NH-1]);
         always_comb begin
            if (known && !func_i[2]) begin
               if (fa == '0 || fb == '0) begin
                  p_zero_prod_passthru_r3: assert (rs == ac)
                     else $error("narrow lane %0d: zero product changed addend", g);
               end
               if (!func_i[1] && ac == N_MAX && nz_pos) begin
                  p_clamp_max_r6: assert (rs == N_MAX)
                     else $error("narrow lane %0d: positive overflow not clamped", g);
               end
               if (func_i[1] && ac == N_MIN && nz_pos) begin
                  p_clamp_min_r6: assert (rs == N_MIN)
                     else $error("narrow lane %0d: negative overflow not clamped", g);
               end
            end
         end
      end
      for (genvar g = 0; g < N_WL; g++) begin : g_wl
         logic [WH-1:0] fa, fb;
         assign fa = func_i[0] ? fac_a_i[g*WW+WH +: WH] : fac_a_i[g*WW +: WH];
         assign fb = func_i[0] ? fac_b_i[g*WW+WH +: WH] : fac_b_i[g*WW +: WH];
         always_comb begin
            if (known && func_i[2] && (fa == '0 || fb == '0)) begin
               p_wide_passthru_r5: assert (res_o[g*WW +: WW] == addend_i[g*WW +: WW])
                  else $error("wide lane %0d: zero product changed addend", g);
            end
         end
      end
   endgenerate

endmodule

bind simd_sat_mac simd_sat_mac_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
   .func_i   (func_i),
   .addend_i (addend_i),
   .fac_a_i  (fac_a_i),
   .fac_b_i  (fac_b_i),
   .res_o    (res_o)
);

// File: tb/tb_simd_sat_mac.sv
`timescale 1ns/100ps
module tb_simd_sat_mac;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   // small configuration, both overflow variants
   logic [2:0] s_fn;
   logic [7:0] s_add, s_fa, s_fb, s_res_g, s_res_s;
   // default configuration
   logic [2:0]   f_fn;
   logic [127:0] f_add, f_fa, f_fb, f_res;

   simd_sat_mac #(.DATA_W(8), .NARROW_W(4), .SIGN_CMP_OVF(1'b0)) dut (
      .func_i(s_fn), .addend_i(s_add), .fac_a_i(s_fa), .fac_b_i(s_fb), .res_o(s_res_g));
   simd_sat_mac #(.DATA_W(8), .NARROW_W(4), .SIGN_CMP_OVF(1'b1)) dut_sc (
      .func_i(s_fn), .addend_i(s_add), .fac_a_i(s_fa), .fac_b_i(s_fb), .res_o(s_res_s));
   simd_sat_mac dut_full (
      .func_i(f_fn), .addend_i(f_add), .fac_a_i(f_fa), .fac_b_i(f_fb), .res_o(f_res));

   function automatic logic signed [131:0] sext(logic [127:0] v, int w);
      logic signed [131:0] t = '0;
      for (int b = 0; b < w; b++) t[b] = v[b];
      if (v[w-1]) t = t - (132'sd1 <<< w);
      return t;
   endfunction

   function automatic logic [127:0] ref_mac(int dw, int nw, logic [2:0] fn,
                                            logic [127:0] ad, logic [127:0] a,
                                            logic [127:0] b);
      int lw = fn[2] ? 2*nw : nw;
      int hw = lw / 2;
      int off = fn[0] ? hw : 0;
      logic [127:0] r = '0;
      for (int i = 0; i < dw/lw; i++) begin
         logic signed [131:0] acc, x, y, res, lim;
         acc = sext(ad >> (i*lw), lw);
         x   = sext(a >> (i*lw + off), hw);
         y   = sext(b >> (i*lw + off), hw);
         res = fn[1] ? acc - x*y : acc + x*y;
         lim = 132'sd1 <<< (lw-1);
         if (res > lim - 1) res = lim - 1;
         else if (res < -lim) res = -lim;
         for (int k = 0; k < lw; k++) r[i*lw+k] = res[k];
      end
      return r;
   endfunction

   task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic full_vec(string tag, logic [2:0] fn, logic [127:0] ad,
                           logic [127:0] a, logic [127:0] b, logic [127:0] exp);
      f_fn = fn; f_add = ad; f_fa = a; f_fb = b;
      #0.5;
      check(tag, f_res, exp);
      #0.5;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      string tag;
      s_fn = '0; s_add = '0; s_fa = '0; s_fb = '0;
      f_fn = '0; f_add = '0; f_fa = '0; f_fb = '0;
      #1;
      // idle state: zero operands give zero (R3)
      check("R3 zero-operands small", {120'd0, s_res_g}, 128'd0);
      check("R3 zero-operands full", f_res, 128'd0);

      // near-exhaustive sweep of the small configuration
      for (int fn = 0; fn < 8; fn++) begin
         case (fn)
            0, 1:    tag = "R1 R2 R3 R9 narrow-add";
            2, 3:    tag = "R1 R2 R4 R6 R9 narrow-sub";
            default: tag = "R1 R2 R5 R6 R8 R9 wide";
         endcase
         for (int n = 0; n < 65536; n++) begin
            logic [7:0] ad, a, b;
            logic [127:0] e;
            ad = n[7:0];
            a  = n[15:8];
            b  = 8'((n[15:8] * 29) + (n[7:0] * 71) + fn);
            s_fn = 3'(fn); s_add = ad; s_fa = a; s_fb = b;
            e = ref_mac(8, 4, 3'(fn), {120'd0, ad}, {120'd0, a}, {120'd0, b});
            #0.5;
            check(tag, {120'd0, s_res_g}, e);
            check({tag, " sign-compare"}, {120'd0, s_res_s}, e);
            #0.5;
         end
      end

      // R7: most negative 16-bit square fits, 0x40000000 per word
      full_vec("R7 square-no-clamp", 3'b000, '0,
               {4{32'h0000_8000}}, {4{32'h0000_8000}}, {4{32'h4000_0000}});
      full_vec("R7 square-then-sub-clamp", 3'b011, {4{32'h8000_0000}},
               {4{32'h8000_0000}}, {4{32'h8000_0000}}, {4{32'h8000_0000}});
      // R2: upper versus lower halves (3*2=6, 7*5=35)
      full_vec("R2 upper-halves", 3'b001, '0, {4{32'h0003_0007}},
               {4{32'h0002_0005}}, {4{32'h0000_0006}});
      full_vec("R2 lower-halves", 3'b000, '0, {4{32'h0003_0007}},
               {4{32'h0002_0005}}, {4{32'h0000_0023}});
      // R8: lane 0 saturates, lane 1 computes 10+2*3
      full_vec("R8 lane-isolation", 3'b000,
               {32'd0, 32'd0, 32'd10, 32'h7fff_ffff},
               {32'd0, 32'd0, 32'd2, 32'd1}, {32'd0, 32'd0, 32'd3, 32'd5},
               {32'd0, 32'd0, 32'd16, 32'h7fff_ffff});
      // R6 / R5: wide lanes, 2^62 product on both limits
      full_vec("R6 wide-clamp-max", 3'b100,
               {64'd5, 64'h7fff_ffff_ffff_ffff}, {2{64'h0000_0000_8000_0000}},
               {2{64'h0000_0000_8000_0000}},
               {64'h4000_0000_0000_0005, 64'h7fff_ffff_ffff_ffff});
      full_vec("R6 wide-clamp-min", 3'b110,
               {2{64'h8000_0000_0000_0000}}, {2{64'h0000_0000_8000_0000}},
               {2{64'h0000_0000_8000_0000}}, {2{64'h8000_0000_0000_0000}});
      full_vec("R5 wide-upper-sub", 3'b111, {64'd100, 64'd0},
               {64'h0000_0004_0000_0000, 64'hffff_ffff_0000_0000},
               {64'h0000_0005_0000_0000, 64'h0000_0003_0000_0000},
               {64'd80, 64'd3});

      // pseudo-random operands on the default configuration
      for (int k = 0; k < 400; k++) begin
         logic [127:0] ad, a, b;
         ad = {$urandom(), $urandom(), $urandom(), $urandom()};
         a  = {$urandom(), $urandom(), $urandom(), $urandom()};
         b  = {$urandom(), $urandom(), $urandom(), $urandom()};
         full_vec("R1 R3 R4 R5 R6 random-full", 3'(k), ad, a, b,
                  ref_mac(128, 32, 3'(k), ad, a, b));
      end

      summary();
      $finish;
   end

endmodule